// File: doc/BRIEF.md
# Alert Tone Guard-Time Qualifier

This block takes the outputs of two tone detectors that cover the upper and lower tones of a dual-tone alert. It turns them into a clean alert signal. A raw flag is high when both tones are heard at once. That raw flag then passes through a digital guard timer, which does the job of an external RC network. The alert goes high only after the raw flag has stayed high for a programmable present time. It goes low only after the raw flag has stayed low for a programmable absent time, which can differ from the present time. Short bursts are rejected and brief dropouts are bridged. Both the raw flag and the guarded alert are brought out.

Detection runs only while the FSK enable input is low. After that input falls, the block waits an enable time before the raw flag can rise. A sleep input clears the guard state at once. The block also merges three sources into one active-low interrupt: the active-low ring indication, the active-low data-ready indication and the guarded alert. The interrupt path keeps working during sleep.

All times are parameters in milliseconds, scaled by a cycles-per-millisecond parameter. In this text, P, A and E are the present, absent and enable times expressed in clock cycles.

Top module: `alert_guard_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `tone_raw` and `alert` are 0 and `irq_n` is 1.
- R2: `tone_raw` is 1 exactly one cycle after both `tone_hi_det` and `tone_lo_det` were sampled high while detection was enabled. If only one tone detector is high, `tone_raw` stays 0.
- R3: After `fsk_en` is sampled low (with `sleep` low), `tone_raw` stays 0 for E clock edges. It can first be 1 after edge E+1.
- R4: `alert` rises exactly P cycles after `tone_raw` rises, if `tone_raw` stays high. A run of `tone_raw` high shorter than P cycles leaves `alert` at 0.
- R5: `alert` falls exactly A cycles after `tone_raw` falls. A dropout shorter than A cycles leaves `alert` at 1.
- R6: Any break in the run restarts the guard count from zero. Two runs of P-1 cycles separated by a one-cycle gap do not raise `alert`. A following unbroken run raises it P cycles after its own start.
- R7: `fsk_en` sampled high drives `tone_raw` and `alert` to 0 on the next cycle. The enable time of R3 restarts when it falls again.
- R8: `sleep` sampled high drives `tone_raw` and `alert` to 0 on the next cycle. The enable time restarts when `sleep` falls.
- R9: `irq_n` is 0 on the cycle after any of the following is sampled: `ring_n` low, `dready_n` low, or `alert` high. It returns to 1 only on the cycle after all three are inactive. This also holds during sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fsk_en | input | 1 | High selects data reception and disables alert detection |
| sleep | input | 1 | High forces the alert path idle |
| tone_hi_det | input | 1 | Upper alert tone present |
| tone_lo_det | input | 1 | Lower alert tone present |
| ring_n | input | 1 | Ring indication, active low |
| dready_n | input | 1 | Data-ready indication, active low |
| tone_raw | output | 1 | Registered both-tones flag, no guard time |
| alert | output | 1 | Guard-qualified alert |
| irq_n | output | 1 | Merged interrupt, active low |

## Verification
The hardest case to reach from the ports is a guard count that is interrupted and has to restart. From outside, a counter that restarts cannot be told apart from one that merely pauses unless the timing is exact.

The stimulus therefore places tone runs of exactly P-1 cycles with single-cycle gaps. It then starts an unbroken run and samples `alert` in the single cycle where a restarted count and a resumed count would differ. The absent side is exercised the same way, with dropouts one cycle shorter than A.

// File: rtl/alert_guard_pkg.sv
package alert_guard_pkg;

  typedef enum logic {
    LVL_IDLE  = 1'b0,
    LVL_ALERT = 1'b1
  } guard_lvl_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold values 0..n
  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/alert_enable_gate.sv
module alert_enable_gate
  import alert_guard_pkg::*;
#(
  parameter int unsigned EN_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fsk_en,
  input  logic sleep,
  output logic det_en
);

  logic det_en_q;

  generate
    if (EN_CYC == 0) begin : g_no_wait
      always_ff @(posedge clk) begin
        if (rst) det_en_q <= 1'b0;
        else     det_en_q <= ~(fsk_en | sleep);
      end
    end else begin : g_wait
      localparam int unsigned EW = width_for(EN_CYC);
      localparam logic [EW-1:0] EN_LAST = EW'(EN_CYC - 1);
      logic [EW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst || fsk_en || sleep) begin
          cnt_q    <= '0;
          det_en_q <= 1'b0;
        end else if (!det_en_q) begin
          if (cnt_q == EN_LAST) begin
            cnt_q    <= '0;
            det_en_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  endgenerate

  assign det_en = det_en_q;

endmodule

// File: rtl/alert_guard_timer.sv
module alert_guard_timer
  import alert_guard_pkg::*;
#(
  parameter int unsigned PRES_CYC = 12,
  parameter int unsigned ABS_CYC  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic raw,
  output logic alert
);

  localparam int unsigned CW = width_for(max_u(PRES_CYC, ABS_CYC));
  localparam logic [CW-1:0] PRES_LAST = CW'(PRES_CYC - 1);
  localparam logic [CW-1:0] ABS_LAST  = CW'(ABS_CYC - 1);

  guard_lvl_e    lvl_q;
  logic [CW-1:0] cnt_q;
  logic          lvl_high;
  logic          mismatch;
  logic [CW-1:0] limit;

  assign lvl_high = (lvl_q == LVL_ALERT);
  assign mismatch = (raw != lvl_high);
  assign limit    = lvl_high ? ABS_LAST : PRES_LAST;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      lvl_q <= LVL_IDLE;
      cnt_q <= '0;
    end else if (!mismatch) begin
      cnt_q <= '0;
    end else if (cnt_q == limit) begin
      lvl_q <= lvl_high ? LVL_IDLE : LVL_ALERT;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign alert = lvl_high;

endmodule

// File: rtl/alert_irq_merge.sv
module alert_irq_merge #(
  parameter int unsigned     N_SRC    = 3,
  parameter logic [N_SRC-1:0] ACT_HIGH = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src,
  output logic             irq_n
);

  logic [N_SRC-1:0] active;
  logic             irq_n_q;

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (ACT_HIGH[i]) begin : g_hi
        assign active[i] = src[i];
      end else begin : g_lo
        assign active[i] = ~src[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else     irq_n_q <= ~(|active);
  end

  assign irq_n = irq_n_q;

endmodule

// File: rtl/alert_guard_top.sv
module alert_guard_top #(
  parameter int unsigned CYC_PER_MS = 3580,
  parameter int unsigned PRESENT_MS = 40,
  parameter int unsigned ABSENT_MS  = 40,
  parameter int unsigned ENABLE_MS  = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic fsk_en,
  input  logic sleep,
  input  logic tone_hi_det,
  input  logic tone_lo_det,
  input  logic ring_n,
  input  logic dready_n,
  output logic tone_raw,
  output logic alert,
  output logic irq_n
);

  localparam int unsigned PRES_CYC = PRESENT_MS * CYC_PER_MS;
  localparam int unsigned ABS_CYC  = ABSENT_MS * CYC_PER_MS;
  localparam int unsigned EN_CYC   = ENABLE_MS * CYC_PER_MS;

  logic det_en;
  logic raw_q;
  logic guard_clear;
  logic alert_w;

  alert_enable_gate #(.EN_CYC(EN_CYC)) u_en (
    .clk    (clk),
    .rst    (rst),
    .fsk_en (fsk_en),
    .sleep  (sleep),
    .det_en (det_en)
  );

  always_ff @(posedge clk) begin
    if (rst) raw_q <= 1'b0;
    else     raw_q <= det_en & ~fsk_en & ~sleep & tone_hi_det & tone_lo_det;
  end

  assign guard_clear = ~det_en | fsk_en | sleep;

  alert_guard_timer #(.PRES_CYC(PRES_CYC), .ABS_CYC(ABS_CYC)) u_guard (
    .clk   (clk),
    .rst   (rst),
    .clear (guard_clear),
    .raw   (raw_q),
    .alert (alert_w)
  );

  alert_irq_merge #(.N_SRC(3), .ACT_HIGH(3'b100)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .src   ({alert_w, dready_n, ring_n}),
    .irq_n (irq_n)
  );

  assign tone_raw = raw_q;
  assign alert    = alert_w;

endmodule

// File: rtl/alert_guard_checker.sv
module alert_guard_checker #(
  parameter int unsigned PRES_CYC = 12,
  parameter int unsigned EN_CYC   = 8
) (
  input logic clk,
  input logic rst,
  input logic fsk_en,
  input logic sleep,
  input logic tone_hi_det,
  input logic tone_lo_det,
  input logic ring_n,
  input logic dready_n,
  input logic tone_raw,
  input logic alert,
  input logic irq_n
);

  logic [31:0] hi_run;
  logic [31:0] en_run;

  always_ff @(posedge clk) begin
    if (rst || !tone_raw) hi_run <= '0;
    else if (hi_run != '1) hi_run <= hi_run + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || fsk_en || sleep) en_run <= '0;
    else if (en_run != '1)      en_run <= en_run + 1'b1;
  end

  assert_raw_both_R2: assert property (@(posedge clk) disable iff (rst)
    tone_raw |-> $past(tone_hi_det && tone_lo_det));

  assert_enable_wait_R3: assert property (@(posedge clk) disable iff (rst)
    tone_raw |-> (en_run >= EN_CYC));

  assert_present_guard_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(alert) |-> (hi_run >= PRES_CYC));

  assert_absent_guard_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(alert) && !$past(fsk_en) && !$past(sleep)) |-> !$past(tone_raw));

  assert_fsk_clears_R7: assert property (@(posedge clk) disable iff (rst)
    fsk_en |=> (!alert && !tone_raw));

  assert_sleep_clears_R8: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (!alert && !tone_raw));

  assert_irq_set_R9: assert property (@(posedge clk) disable iff (rst)
    (!ring_n || !dready_n || alert) |=> !irq_n);

  assert_irq_release_R9: assert property (@(posedge clk) disable iff (rst)
    (ring_n && dready_n && !alert) |=> irq_n);

endmodule

bind alert_guard_top alert_guard_checker #(
  .PRES_CYC (PRES_CYC),
  .EN_CYC   (EN_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fsk_en      (fsk_en),
  .sleep       (sleep),
  .tone_hi_det (tone_hi_det),
  .tone_lo_det (tone_lo_det),
  .ring_n      (ring_n),
  .dready_n    (dready_n),
  .tone_raw    (tone_raw),
  .alert       (alert),
  .irq_n       (irq_n)
);

// File: tb/alert_guard_top_tb.sv
`timescale 1ns/1ps
module alert_guard_top_tb;

  localparam int unsigned CPM = 4;
  localparam int unsigned PMS = 3;
  localparam int unsigned AMS = 2;
  localparam int unsigned EMS = 2;
  localparam int unsigned P = PMS * CPM;
  localparam int unsigned A = AMS * CPM;
  localparam int unsigned E = EMS * CPM;

  localparam int S_RAW = 0;
  localparam int S_ALERT = 1;
  localparam int S_IRQ = 2;

  logic clk = 1'b0;
  logic rst, fsk_en, sleep, tone_hi_det, tone_lo_det, ring_n, dready_n;
  logic tone_raw, alert, irq_n;

  always #2 clk = ~clk;

  alert_guard_top #(
    .CYC_PER_MS(CPM), .PRESENT_MS(PMS), .ABSENT_MS(AMS), .ENABLE_MS(EMS)
  ) u_dut (
    .clk(clk), .rst(rst), .fsk_en(fsk_en), .sleep(sleep),
    .tone_hi_det(tone_hi_det), .tone_lo_det(tone_lo_det),
    .ring_n(ring_n), .dready_n(dready_n),
    .tone_raw(tone_raw), .alert(alert), .irq_n(irq_n)
  );

  typedef struct {
    int unsigned at;
    int          sig;
    logic        val;
    string       req;
  } exp_t;

  exp_t        q[$];
  int unsigned edges = 0;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always @(posedge clk) edges <= edges + 1;

  task automatic expect_at(input int unsigned at, input int sig, input logic v, input string req);
    exp_t e;
    e.at = at; e.sig = sig; e.val = v; e.req = req;
    q.push_back(e);
  endtask

  task automatic wait_n(input int unsigned n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop expectations whose cycle has come and compare
  initial begin
    forever begin
      @(negedge clk);
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].at == edges) begin
          logic act;
          string nm;
          case (q[i].sig)
            S_RAW:   begin act = tone_raw; nm = "tone_raw"; end
            S_ALERT: begin act = alert;    nm = "alert";    end
            default: begin act = irq_n;    nm = "irq_n";    end
          endcase
          n_tests++;
          if (act !== q[i].val) begin
            n_fail++;
            $display("FAIL %s %s at edge %0d: actual=%b expected=%b",
                     q[i].req, nm, edges, act, q[i].val);
          end
          q.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned b, r;
    rst = 1'b1; fsk_en = 1'b1; sleep = 1'b0;
    tone_hi_det = 1'b0; tone_lo_det = 1'b0; ring_n = 1'b1; dready_n = 1'b1;
    wait_n(3);
    rst = 1'b0;
    b = edges;
    expect_at(b + 1, S_RAW, 1'b0, "R1");
    expect_at(b + 1, S_ALERT, 1'b0, "R1");
    expect_at(b + 1, S_IRQ, 1'b1, "R1");
    wait_n(3);

    // enable wait then present guard
    b = edges;
    fsk_en = 1'b0; tone_hi_det = 1'b1; tone_lo_det = 1'b1;
    expect_at(b + E, S_RAW, 1'b0, "R3");
    expect_at(b + E + 1, S_RAW, 1'b1, "R2");
    r = b + E + 1;
    expect_at(r + P - 1, S_ALERT, 1'b0, "R4");
    expect_at(r + P, S_ALERT, 1'b1, "R4");
    expect_at(r + P, S_IRQ, 1'b1, "R9");
    expect_at(r + P + 1, S_IRQ, 1'b0, "R9");
    wait_n(E + P + 3);

    // single tone: raw drops, alert falls after absent guard
    b = edges;
    tone_lo_det = 1'b0;
    expect_at(b + 1, S_RAW, 1'b0, "R2");
    expect_at(b + A, S_ALERT, 1'b1, "R5");
    expect_at(b + A + 1, S_ALERT, 1'b0, "R5");
    expect_at(b + A + 2, S_IRQ, 1'b1, "R9");
    expect_at(b + A + 4, S_RAW, 1'b0, "R2");
    wait_n(A + 5);

    // short present run rejected
    b = edges;
    tone_lo_det = 1'b1;
    wait_n(P - 1);
    tone_lo_det = 1'b0;
    expect_at(b + P + 2, S_ALERT, 1'b0, "R4");
    expect_at(b + P + 5, S_ALERT, 1'b0, "R4");
    wait_n(8);

    // restart: two P-1 runs with a one-cycle gap, then an unbroken run
    tone_lo_det = 1'b1;
    wait_n(P - 1);
    tone_lo_det = 1'b0;
    wait_n(1);
    tone_lo_det = 1'b1;
    wait_n(P - 1);
    tone_lo_det = 1'b0;
    b = edges;
    expect_at(b + 3, S_ALERT, 1'b0, "R6");
    wait_n(1);
    b = edges;
    tone_lo_det = 1'b1;
    r = b + 1;
    expect_at(r + P - 1, S_ALERT, 1'b0, "R6");
    expect_at(r + P, S_ALERT, 1'b1, "R6");
    wait_n(P + 3);

    // dropouts of A-1 cycles are bridged, repeated to test absent restart
    tone_lo_det = 1'b0;
    wait_n(A - 1);
    tone_lo_det = 1'b1;
    wait_n(1);
    tone_lo_det = 1'b0;
    wait_n(A - 1);
    tone_lo_det = 1'b1;
    b = edges;
    expect_at(b + 2, S_ALERT, 1'b1, "R5");
    expect_at(b + 4, S_ALERT, 1'b1, "R5");
    wait_n(6);

    // sleep forces idle, ring still interrupts
    b = edges;
    sleep = 1'b1;
    expect_at(b + 1, S_ALERT, 1'b0, "R8");
    expect_at(b + 1, S_RAW, 1'b0, "R8");
    expect_at(b + 2, S_IRQ, 1'b1, "R8");
    wait_n(4);
    b = edges;
    ring_n = 1'b0;
    expect_at(b + 1, S_IRQ, 1'b0, "R9");
    wait_n(2);
    b = edges;
    ring_n = 1'b1;
    expect_at(b + 1, S_IRQ, 1'b1, "R9");
    wait_n(2);
    b = edges;
    sleep = 1'b0;
    expect_at(b + E, S_RAW, 1'b0, "R8");
    expect_at(b + E + 1, S_RAW, 1'b1, "R8");
    expect_at(b + E + 1 + P, S_ALERT, 1'b1, "R4");
    wait_n(E + P + 3);

    // fsk enable forces idle, enable time restarts
    b = edges;
    fsk_en = 1'b1;
    expect_at(b + 1, S_ALERT, 1'b0, "R7");
    expect_at(b + 1, S_RAW, 1'b0, "R7");
    expect_at(b + 2, S_IRQ, 1'b1, "R7");
    wait_n(4);
    b = edges;
    fsk_en = 1'b0;
    expect_at(b + E, S_RAW, 1'b0, "R7");
    expect_at(b + E + 1, S_RAW, 1'b1, "R7");
    wait_n(E + 3);
    tone_lo_det = 1'b0;
    wait_n(A + 4);

    // interrupt merge with overlapping sources
    b = edges;
    dready_n = 1'b0;
    expect_at(b + 1, S_IRQ, 1'b0, "R9");
    wait_n(2);
    ring_n = 1'b0;
    wait_n(2);
    b = edges;
    dready_n = 1'b1;
    expect_at(b + 1, S_IRQ, 1'b0, "R9");
    wait_n(2);
    b = edges;
    ring_n = 1'b1;
    expect_at(b + 1, S_IRQ, 1'b1, "R9");
    wait_n(3);

    while (q.size() != 0) wait_n(1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule